// File: doc/BRIEF.md
# Qualified Window Alarm Controller

This block turns two streams of digitized monitor samples (for example a ground-shift reading and a protective-earth continuity reading) into a safety alarm decision that does not chatter. Each channel is compared against a programmable window with hysteresis. A fault is escalated only when both channels agree that the value is out of window, and only after that agreement has lasted for a programmed number of consecutive samples. The decision moves through Normal, Suspect, Confirmed and Latched states. Once latched, the relay drive holds until a qualified reset request is accepted.

A separate path watches whether each input can be trusted. A sample flagged invalid, or a value that has not changed for too long, sends the block into a dedicated untrusted state that raises the alarm. Silence on a channel is therefore never taken as a healthy reading. The block also comes out of reset in this untrusted state, so the alarm is asserted until real in-window data arrives. Every state change produces a one-cycle strobe that carries the old state, the new state and the qualify count, so a logger can record the decision.

Top module: `qa_ctrl`

## Requirements
- R1: Each channel is out of window when its sample is below `win_lo` or above `win_hi`. Once out, it returns in window only when `win_lo + win_hyst <= sample` and `sample + win_hyst <= win_hi`. The channel's window flag updates only on samples whose valid bit is set.
- R2: Agreeing out-of-window samples raise the qualify count by one each. When the count reaches `qual_lim`, the state becomes Confirmed (code 2). Below that count the state is Suspect (code 1). Cycles without `smp_en` neither advance nor break the count.
- R3: A sample where only one channel is out of window does not escalate. From Normal (code 0) the state stays Normal.
- R4: A sample in which either channel is not trusted moves the state to Untrusted (code 4) and clears the count, unless the state is Latched. Untrusted returns to Normal only on a sample where both channels are trusted and in window.
- R5: In Suspect, a sample without agreement returns the state to Normal, clears the count and raises `spike_cnt` by one (saturating). Suspect never goes directly to Latched.
- R6: Confirmed moves to Latched (code 3) on the next sample. While Latched, `relay` stays 1 and only an accepted reset request clears it.
- R7: `rst_req` is accepted only in Latched and only when both channels are trusted and both current samples satisfy the inner-window condition of R1. An accepted request moves the state to Normal with count 0. A request that is not accepted has no effect on the state or the outputs.
- R8: A channel is stuck, and so untrusted, when its sample has equalled the previous sample on at least `stuck_lim` consecutive samples. A `stuck_lim` of 0 disables the check.
- R9: After reset the state is Untrusted and `alarm` is 1. `alarm` is 1 exactly in Confirmed, Latched and Untrusted.
- R10: `grade` is 0 (info) in Normal, 1 (warn) in Suspect and 2 (alarm) in every other state.
- R11: In the cycle after a state change, `trans_stb` is 1 for one cycle. At the same time `trans_from` holds the previous state, `trans_to` the new state, and `trans_cnt` the qualify count after the decision.
- R12: The registered state and all outputs change one clock after the sample or request that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | A new sample pair is present this cycle |
| a_data | input | DW | Channel A sample |
| a_ok | input | 1 | Channel A sample valid |
| b_data | input | DW | Channel B sample |
| b_ok | input | 1 | Channel B sample valid |
| win_lo | input | DW | Lower window bound |
| win_hi | input | DW | Upper window bound |
| win_hyst | input | DW | Hysteresis margin for re-entry |
| qual_lim | input | CW | Agreeing samples needed to confirm |
| stuck_lim | input | CW | Repeated-value limit for the stuck check, 0 disables it |
| rst_req | input | 1 | Request to clear a latched alarm |
| alarm | output | 1 | Alarm level |
| relay | output | 1 | Hard action drive |
| grade | output | 2 | Graded status: 0 info, 1 warn, 2 alarm |
| state | output | 3 | State code |
| trans_stb | output | 1 | One-cycle transition strobe |
| trans_from | output | 3 | State before the transition |
| trans_to | output | 3 | State after the transition |
| trans_cnt | output | CW | Qualify count at the transition |
| spike_cnt | output | SW | Count of Suspect episodes that fell back |

## Verification
The controller is driven with short two-channel excursions that must fall back and raise the spike count, and with one-channel excursions that must not escalate, which separates agreement from single-input triggering. Excursions that drop into the hysteresis band without reaching the inner window separate the hysteretic return from a plain threshold. Sample trains with idle gaps show that the count follows samples rather than clock cycles. Invalid flags, frozen values and reset requests under untrusted or band-edge data show that the untrusted path and the reset gate cannot be bypassed.

// File: rtl/qa_pkg.sv
package qa_pkg;
    typedef enum logic [2:0] {
        ST_NORM  = 3'd0,
        ST_SUSP  = 3'd1,
        ST_CONF  = 3'd2,
        ST_LATCH = 3'd3,
        ST_UNTR  = 3'd4
    } qa_state_e;

    typedef enum logic [1:0] {
        GR_INFO  = 2'd0,
        GR_WARN  = 2'd1,
        GR_ALARM = 2'd2
    } qa_grade_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/qa_chan.sv
module qa_chan #(
    parameter int DW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic [DW-1:0] data,
    input  logic          ok,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] hyst,
    input  logic [CW-1:0] stuck_lim,
    output logic          oow,
    output logic          inner,
    output logic          trusted
);
    localparam logic [CW-1:0] REP_MAX = '1;

    typedef struct packed {
        logic          oow;
        logic [DW-1:0] last;
        logic [CW-1:0] rep;
    } ch_t;

    ch_t ch_d, ch_q;

    logic [DW:0]   lo_in, d_pl;
    logic          outside, stuck;
    logic [CW-1:0] rep_now;

    always_comb begin
        lo_in   = {1'b0, lo} + {1'b0, hyst};
        d_pl    = {1'b0, data} + {1'b0, hyst};
        inner   = ({1'b0, data} >= lo_in) && (d_pl <= {1'b0, hi});
        outside = (data < lo) || (data > hi);
        oow     = ch_q.oow ? !inner : outside;
        if (data == ch_q.last)
            rep_now = (ch_q.rep == REP_MAX) ? ch_q.rep : ch_q.rep + 1'b1;
        else
            rep_now = '0;
        stuck   = (stuck_lim != '0) && (rep_now >= stuck_lim);
        trusted = ok && !stuck;

        ch_d = ch_q;
        if (smp_en) begin
            ch_d.last = data;
            ch_d.rep  = rep_now;
            if (ok) ch_d.oow = oow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    // R1
    oow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_q.oow) |-> $past(outside && ok && smp_en));
    // R1
    oow_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_q.oow) |-> $past(inner && ok && smp_en));
endmodule

// File: rtl/qa_ctrl.sv
module qa_ctrl
    import qa_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic [DW-1:0] a_data,
    input  logic          a_ok,
    input  logic [DW-1:0] b_data,
    input  logic          b_ok,
    input  logic [DW-1:0] win_lo,
    input  logic [DW-1:0] win_hi,
    input  logic [DW-1:0] win_hyst,
    input  logic [CW-1:0] qual_lim,
    input  logic [CW-1:0] stuck_lim,
    input  logic          rst_req,
    output logic          alarm,
    output logic          relay,
    output logic [1:0]    grade,
    output logic [2:0]    state,
    output logic          trans_stb,
    output logic [2:0]    trans_from,
    output logic [2:0]    trans_to,
    output logic [CW-1:0] trans_cnt,
    output logic [SW-1:0] spike_cnt
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [SW-1:0] SPK_MAX = '1;

    typedef struct packed {
        qa_state_e     st;
        logic [CW-1:0] cnt;
        logic [SW-1:0] spk;
        logic          stb;
        qa_state_e     from;
        qa_state_e     to;
        logic [CW-1:0] tcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DW-1:0]     ch_dat [NUM_CH];
    logic [NUM_CH-1:0] ch_ok, ch_oow, ch_inner, ch_trust;
    logic              all_trust, both_oow, none_oow, rst_take;

    assign ch_dat[0] = a_data;
    assign ch_dat[1] = b_data;
    assign ch_ok     = {b_ok, a_ok};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qa_chan #(.DW(DW), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_en    (smp_en),
            .data      (ch_dat[c]),
            .ok        (ch_ok[c]),
            .lo        (win_lo),
            .hi        (win_hi),
            .hyst      (win_hyst),
            .stuck_lim (stuck_lim),
            .oow       (ch_oow[c]),
            .inner     (ch_inner[c]),
            .trusted   (ch_trust[c])
        );
    end

    always_comb begin
        all_trust = &ch_trust;
        both_oow  = &ch_oow;
        none_oow  = ~|ch_oow;
        rst_take  = rst_req && (ctl_q.st == ST_LATCH) && all_trust && (&ch_inner);

        ctl_d     = ctl_q;
        ctl_d.stb = 1'b0;

        if (rst_take) begin
            ctl_d.st  = ST_NORM;
            ctl_d.cnt = '0;
        end else if (smp_en) begin
            if (!all_trust) begin
                if (ctl_q.st != ST_LATCH) begin
                    ctl_d.st  = ST_UNTR;
                    ctl_d.cnt = '0;
                end
            end else begin
                unique case (ctl_q.st)
                    ST_UNTR: begin
                        if (none_oow) begin
                            ctl_d.st  = ST_NORM;
                            ctl_d.cnt = '0;
                        end
                    end
                    ST_NORM, ST_SUSP: begin
                        if (both_oow) begin
                            ctl_d.cnt = (ctl_q.cnt == CNT_MAX) ? ctl_q.cnt : ctl_q.cnt + 1'b1;
                            ctl_d.st  = (ctl_d.cnt >= qual_lim) ? ST_CONF : ST_SUSP;
                        end else begin
                            if (ctl_q.st == ST_SUSP && ctl_q.spk != SPK_MAX)
                                ctl_d.spk = ctl_q.spk + 1'b1;
                            ctl_d.st  = ST_NORM;
                            ctl_d.cnt = '0;
                        end
                    end
                    ST_CONF:  ctl_d.st = ST_LATCH;
                    default:  ctl_d.st = ctl_q.st;
                endcase
            end
        end

        if (ctl_d.st != ctl_q.st) begin
            ctl_d.stb  = 1'b1;
            ctl_d.from = ctl_q.st;
            ctl_d.to   = ctl_d.st;
            ctl_d.tcnt = ctl_d.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_UNTR;
            ctl_q.from <= ST_UNTR;
            ctl_q.to   <= ST_UNTR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        state      = ctl_q.st;
        alarm      = (ctl_q.st == ST_CONF) || (ctl_q.st == ST_LATCH) || (ctl_q.st == ST_UNTR);
        relay      = (ctl_q.st == ST_LATCH);
        grade      = (ctl_q.st == ST_NORM) ? GR_INFO :
                     (ctl_q.st == ST_SUSP) ? GR_WARN : GR_ALARM;
        trans_stb  = ctl_q.stb;
        trans_from = ctl_q.from;
        trans_to   = ctl_q.to;
        trans_cnt  = ctl_q.tcnt;
        spike_cnt  = ctl_q.spk;
    end

    // R6
    relay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(relay) |-> $past(rst_req));
    // R7
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LATCH && !rst_take) |=> (ctl_q.st == ST_LATCH));
    // R5
    susp_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SUSP) |=> (ctl_q.st != ST_LATCH));
    // R2
    conf_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_CONF) |-> (ctl_q.cnt >= qual_lim));
    // R4
    untr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_NORM && $past(ctl_q.st) == ST_UNTR) |-> $past(&ch_trust && smp_en));
    // R11
    strobe_from_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trans_stb |-> ($past(ctl_q.st) == trans_from));
endmodule

// File: tb/sim_qa_ctrl.sv
`timescale 1ns/1ps
module sim_qa_ctrl;
    localparam int DW = 12;
    localparam int CW = 8;
    localparam int SW = 8;
    localparam int LO = 100, HI = 200, HY = 10, QL = 4, SL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0, a_ok = 1'b0, b_ok = 1'b0, rst_req = 1'b0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic alarm, relay, trans_stb;
    logic [1:0] grade;
    logic [2:0] state, trans_from, trans_to;
    logic [CW-1:0] trans_cnt;
    logic [SW-1:0] spike_cnt;

    always #2.5 clk = ~clk;

    qa_ctrl #(.DW(DW), .CW(CW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
        .a_data(a_data), .a_ok(a_ok), .b_data(b_data), .b_ok(b_ok),
        .win_lo(12'(LO)), .win_hi(12'(HI)), .win_hyst(12'(HY)),
        .qual_lim(8'(QL)), .stuck_lim(8'(SL)), .rst_req(rst_req),
        .alarm(alarm), .relay(relay), .grade(grade), .state(state),
        .trans_stb(trans_stb), .trans_from(trans_from), .trans_to(trans_to),
        .trans_cnt(trans_cnt), .spike_cnt(spike_cnt)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural reference
    int ms = 4, mq = 0, msp = 0, mstb = 0, mfrom = 4, mto = 4, mcnt = 0;
    int moow[2] = '{0, 0};
    int mlast[2] = '{0, 0};
    int mrep[2] = '{0, 0};

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model(int en, int ad, int aok, int bd, int bok, int rq);
        int d[2], ok[2], oo[2], inr[2], rn[2], tr[2];
        int ps;
        d[0] = ad; d[1] = bd; ok[0] = aok; ok[1] = bok;
        for (int c = 0; c < 2; c++) begin
            inr[c] = (d[c] >= LO + HY) && (d[c] + HY <= HI);
            oo[c]  = moow[c] ? !inr[c] : (d[c] < LO || d[c] > HI);
            rn[c]  = (d[c] == mlast[c]) ? ((mrep[c] < 255) ? mrep[c] + 1 : 255) : 0;
            tr[c]  = ok[c] && !(SL != 0 && rn[c] >= SL);
        end
        ps = ms;
        if (rq && ms == 3 && tr[0] && tr[1] && inr[0] && inr[1]) begin
            ms = 0; mq = 0;
        end else if (en) begin
            if (!(tr[0] && tr[1])) begin
                if (ms != 3) begin ms = 4; mq = 0; end
            end else if (ms == 4) begin
                if (!oo[0] && !oo[1]) begin ms = 0; mq = 0; end
            end else if (ms == 0 || ms == 1) begin
                if (oo[0] && oo[1]) begin
                    mq = (mq < 255) ? mq + 1 : 255;
                    ms = (mq >= QL) ? 2 : 1;
                end else begin
                    if (ms == 1 && msp < 255) msp++;
                    ms = 0; mq = 0;
                end
            end else if (ms == 2) begin
                ms = 3;
            end
        end
        if (en) begin
            for (int c = 0; c < 2; c++) begin
                mlast[c] = d[c];
                mrep[c]  = rn[c];
                if (ok[c]) moow[c] = oo[c];
            end
        end
        mstb = (ms != ps);
        if (mstb) begin mfrom = ps; mto = ms; mcnt = mq; end
    endtask

    task automatic compare(string req);
        chk(req, "state", state, ms);
        chk("R9", "alarm", alarm, (ms == 2 || ms == 3 || ms == 4));
        chk("R6", "relay", relay, (ms == 3));
        chk("R10", "grade", grade, (ms == 0) ? 0 : (ms == 1) ? 1 : 2);
        chk("R5", "spike_cnt", spike_cnt, msp);
        chk("R11", "trans_stb", trans_stb, mstb);
        if (mstb) begin
            chk("R11", "trans_from", trans_from, mfrom);
            chk("R11", "trans_to", trans_to, mto);
            chk("R11", "trans_cnt", trans_cnt, mcnt);
        end
    endtask

    // one clock: drive after negedge, model at posedge, compare at next negedge (R12)
    task automatic step(int en, int ad, int aok, int bd, int bok, int rq, string req);
        smp_en = en[0]; a_data = ad[DW-1:0]; a_ok = aok[0];
        b_data = bd[DW-1:0]; b_ok = bok[0]; rst_req = rq[0];
        @(posedge clk);
        model(en, ad, aok, bd, bok, rq);
        @(negedge clk);
        compare(req);
    endtask

    task automatic good(int n, int v, string req);
        for (int i = 0; i < n; i++) step(1, v + (i % 2), 1, v + ((i + 1) % 2), 1, 0, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 fail-safe reset state
        chk("R9", "reset state", state, 4);
        chk("R9", "reset alarm", alarm, 1);
        chk("R6", "reset relay", relay, 0);
        step(0, 150, 1, 150, 1, 0, "R9");
        chk("R9", "alarm held without sample", alarm, 1);

        good(8, 150, "R9");
        chk("R9", "normal after valid", state, 0);

        // R5 short two-channel spike
        step(1, 250, 1, 251, 1, 0, "R2");
        chk("R10", "suspect grade", grade, 1);
        step(1, 251, 1, 250, 1, 0, "R2");
        good(3, 150, "R5");
        chk("R5", "spike counted", spike_cnt, 1);

        // R3 one channel out only
        for (int i = 0; i < 6; i++) step(1, 250 + (i % 2), 1, 150 + (i % 2), 1, 0, "R3");
        chk("R3", "no escalation", state, 0);
        good(2, 150, "R3");

        // R1/R2/R6 excursion then drop into hysteresis band
        step(1, 250, 1, 251, 1, 0, "R2");
        step(1, 251, 1, 250, 1, 0, "R2");
        step(1, 195, 1, 196, 1, 0, "R1");
        step(1, 196, 1, 195, 1, 0, "R1");
        chk("R2", "confirmed", state, 2);
        step(1, 195, 1, 196, 1, 0, "R6");
        chk("R6", "latched relay", relay, 1);

        // R7 request in band edge ignored
        step(0, 196, 1, 195, 1, 1, "R7");
        chk("R7", "req ignored band", state, 3);
        good(4, 150, "R6");
        chk("R6", "relay held", relay, 1);
        step(0, 150, 0, 151, 1, 1, "R7");
        chk("R7", "req ignored invalid", relay, 1);
        step(0, 150, 1, 151, 1, 1, "R7");
        chk("R7", "req accepted", state, 0);
        good(3, 150, "R7");

        // single low sample spike
        step(1, 50, 1, 51, 1, 0, "R5");
        good(2, 150, "R5");
        chk("R5", "second spike", spike_cnt, 2);

        // R4 invalid input
        step(1, 150, 0, 151, 1, 0, "R4");
        chk("R4", "untrusted", state, 4);
        step(1, 151, 1, 150, 0, 0, "R4");
        good(3, 150, "R4");
        chk("R4", "recovered", state, 0);

        // R8 frozen channel A
        for (int i = 0; i < 8; i++) step(1, 160, 1, 150 + (i % 2), 1, 0, "R8");
        chk("R8", "stuck untrusted", state, 4);
        good(4, 150, "R8");

        // R2 count across idle gaps, then latch while invalid
        for (int i = 0; i < 4; i++) begin
            step(1, 30 + i, 1, 31 + i, 1, 0, "R2");
            step(0, 30 + i, 1, 31 + i, 1, 0, "R2");
            step(0, 30 + i, 1, 31 + i, 1, 0, "R2");
        end
        chk("R2", "confirmed with gaps", state, 2);
        step(1, 40, 1, 41, 1, 0, "R6");
        step(1, 150, 0, 150, 0, 0, "R4");
        chk("R4", "latch kept when untrusted", state, 3);
        step(1, 150, 1, 151, 1, 0, "R6");
        step(0, 151, 1, 150, 1, 1, "R7");
        chk("R7", "cleared", relay, 0);
        good(3, 150, "R12");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule